// File: doc/BRIEF.md
# Timed Self-Test Phase Sequencer

This block imitates the outward behaviour of a memory self-test engine but reads and writes no memory. A command byte is written into an 8-bit control register by a one-cycle write strobe. A start command moves the engine through three timed phases: preparation, exercise and evaluation. Each phase lasts a programmable number of clock ticks and then hands over to the next. While a run is active the engine reports it in a status byte. At the end of the run the status byte shows whether the run passed, or which phases were made to report a fault.

The block exists so that test-access software can be tried against an instrument with real timing, visible side effects and controllable failures. Command bits can force a fault at the end of the exercise phase or the evaluation phase. Other command bits double the length of any one phase, and one bit aborts a run in progress. Two percentage outputs, 0 to 100, give a power-draw level and a heat level for the current phase. A monitoring instrument elsewhere can pick these up.

Top module: `selftest_sequencer`

## Requirements
- R1: The control register loads `ctrl_data_i` only on a clock edge where `ctrl_wr_i` is 1; a value presented with `ctrl_wr_i` low has no effect on the outputs.
- R2: A write with bit 0 (start) set and bit 1 clear, made while idle, enters the preparation phase on the second clock edge after the write edge. Preparation lasts 10 ticks, exercise 30 and evaluation 20, and the engine is then idle. Status bit 1 (running) is 1 exactly while a phase is active.
- R3: Control bits 4, 5 and 6, taken at start, double the length of the preparation, exercise and evaluation phases respectively.
- R4: When evaluation completes with no fault flag set, status bit 0 (passed) becomes 1 on the same edge that returns the engine to idle. Status bits 7..5 always read 0.
- R5: With control bit 2 set at start, status bit 3 becomes 1 on the edge that leaves the exercise phase. With control bit 3 set at start, status bit 4 becomes 1 on the edge that ends evaluation. In either case passed stays 0.
- R6: A write with bit 1 (abort) set during a run returns the engine to idle on the second edge after the write edge. That edge clears running, sets status bit 2 (aborted) and leaves the fault flags as they are. Abort takes precedence over a start bit in the same write.
- R7: An abort written while idle changes nothing.
- R8: Every accepted start clears the passed, aborted and both fault flags.
- R9: A start written during a run is ignored, and the phase lengths and fault injections keep the values taken at the accepted start.
- R10: Power and heat outputs read 0/0 while idle, 40/20 in preparation, 90/70 in exercise and 50/40 in evaluation.
- R11: An active-low reset at any time returns the engine to idle, with status 0 and a cleared control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr_i | input | 1 | Write strobe for the control register |
| ctrl_data_i | input | 8 | Command byte (bit0 start, bit1 abort, bit2/3 fault injection, bit4/5/6 length doubling, bit7 reserved) |
| status_o | output | 8 | bit0 passed, bit1 running, bit2 aborted, bit3 exercise fault, bit4 evaluation fault, bits 7..5 zero |
| power_o | output | 7 | Power-draw level, 0 to 100 |
| heat_o | output | 7 | Heat level, 0 to 100 |

## Verification
The assertions check the following on every cycle:
- an abort always lands in idle on the next edge;
- preparation can only stay where it is or move on to the exercise phase;
- an accepted start restarts the count at zero;
- passed never coexists with a fault flag;
- passed and aborted are clear during a run;
- idle is always quiet on both activity outputs;
- the control register holds without a write strobe.

Only the bench scenarios can show the exact phase lengths, with and without doubling. They also cover which edge sets each flag, that a start during a run is ignored along with its new configuration, abort precedence, and recovery from a reset in mid-run.

// File: rtl/selftest_pkg.sv
package selftest_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_PREP = 2'd1,
        PH_EXER = 2'd2,
        PH_EVAL = 2'd3
    } phase_e;

    // Command byte layout, MSB first
    typedef struct packed {
        logic rsvd;
        logic dbl_eval;
        logic dbl_exer;
        logic dbl_prep;
        logic inj_eval;
        logic inj_exer;
        logic abort;
        logic start;
    } cmd_t;

    localparam int LVL_W = 7;

    localparam int PWR_PREP  = 40;
    localparam int HEAT_PREP = 20;
    localparam int PWR_EXER  = 90;
    localparam int HEAT_EXER = 70;
    localparam int PWR_EVAL  = 50;
    localparam int HEAT_EVAL = 40;

endpackage

// File: rtl/st_cmd_reg.sv
module st_cmd_reg
    import selftest_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_i,
    input  logic [7:0] data_i,
    output cmd_t       cmd_o,
    output logic       fresh_o
);

    typedef struct packed {
        cmd_t cmd;
        logic fresh;
    } cmd_state_t;

    cmd_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.fresh = 1'b0;
        if (wr_i) begin
            st_d.cmd      = cmd_t'(data_i);
            st_d.cmd.rsvd = 1'b0;
            st_d.fresh    = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_o   = st_q.cmd;
    assign fresh_o = st_q.fresh;

    AST_HOLD_WITHOUT_WR: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(st_q.cmd)); // R1

endmodule

// File: rtl/st_phase_seq.sv
module st_phase_seq
    import selftest_pkg::*;
#(
    parameter int PREP_TICKS = 10,
    parameter int EXER_TICKS = 30,
    parameter int EVAL_TICKS = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  cmd_t       cmd_i,
    input  logic       fresh_i,
    output phase_e     phase_o,
    output logic       phase_end_o,
    output logic       start_ev_o,
    output logic       abort_ev_o,
    output logic [1:0] inj_o
);

    localparam int MAX_A    = (PREP_TICKS > EXER_TICKS) ? PREP_TICKS : EXER_TICKS;
    localparam int MAX_BASE = (MAX_A > EVAL_TICKS) ? MAX_A : EVAL_TICKS;
    localparam int CNT_W    = $clog2(2 * MAX_BASE + 1);
    localparam int N_PHASES = 3;

    typedef struct packed {
        phase_e             phase;
        logic [CNT_W-1:0]   cnt;
        logic [N_PHASES-1:0] dbl;
        logic [1:0]         inj;
    } seq_state_t;

    seq_state_t st_d, st_q;

    // Last count value of each phase; index 0 prep, 1 exercise, 2 evaluation
    logic [CNT_W-1:0] last_cnt [N_PHASES];

    for (genvar g = 0; g < N_PHASES; g++) begin : g_limit
        localparam int BASE = (g == 0) ? PREP_TICKS : ((g == 1) ? EXER_TICKS : EVAL_TICKS);
        assign last_cnt[g] = st_q.dbl[g] ? CNT_W'(2 * BASE - 1) : CNT_W'(BASE - 1);
    end

    logic start_ev, abort_ev, at_end;

    always_comb begin
        start_ev = fresh_i && cmd_i.start && !cmd_i.abort && (st_q.phase == PH_IDLE);
        abort_ev = fresh_i && cmd_i.abort && (st_q.phase != PH_IDLE);
        unique case (st_q.phase)
            PH_PREP: at_end = (st_q.cnt == last_cnt[0]);
            PH_EXER: at_end = (st_q.cnt == last_cnt[1]);
            PH_EVAL: at_end = (st_q.cnt == last_cnt[2]);
            default: at_end = 1'b0;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (abort_ev) begin
            st_d.phase = PH_IDLE;
            st_d.cnt   = '0;
        end else if (start_ev) begin
            st_d.phase = PH_PREP;
            st_d.cnt   = '0;
            st_d.dbl   = {cmd_i.dbl_eval, cmd_i.dbl_exer, cmd_i.dbl_prep};
            st_d.inj   = {cmd_i.inj_eval, cmd_i.inj_exer};
        end else if (st_q.phase != PH_IDLE) begin
            if (at_end) begin
                st_d.cnt = '0;
                unique case (st_q.phase)
                    PH_PREP: st_d.phase = PH_EXER;
                    PH_EXER: st_d.phase = PH_EVAL;
                    default: st_d.phase = PH_IDLE;
                endcase
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, cnt: '0, dbl: '0, inj: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o     = st_q.phase;
    assign phase_end_o = at_end;
    assign start_ev_o  = start_ev;
    assign abort_ev_o  = abort_ev;
    assign inj_o       = st_q.inj;

    AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        abort_ev |=> (st_q.phase == PH_IDLE)); // R6

    AST_PREP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_PREP && !abort_ev) |=> (st_q.phase == PH_PREP || st_q.phase == PH_EXER)); // R2

    AST_START_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (st_q.phase == PH_PREP && st_q.cnt == '0)); // R2

endmodule

// File: rtl/st_status_enc.sv
module st_status_enc
    import selftest_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  phase_e     phase_i,
    input  logic       phase_end_i,
    input  logic       start_ev_i,
    input  logic       abort_ev_i,
    input  logic [1:0] inj_i,
    output logic [7:0] status_o
);

    typedef struct packed {
        logic passed;
        logic aborted;
        logic err_exer;
        logic err_eval;
    } flags_t;

    flags_t fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        if (start_ev_i) begin
            fl_d = '0;
        end else if (abort_ev_i) begin
            fl_d.aborted = 1'b1;
        end else if (phase_end_i) begin
            if (phase_i == PH_EXER && inj_i[0]) begin
                fl_d.err_exer = 1'b1;
            end
            if (phase_i == PH_EVAL) begin
                fl_d.err_eval = inj_i[1];
                fl_d.passed   = !fl_q.err_exer && !inj_i[1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    logic running;
    assign running  = (phase_i != PH_IDLE);
    assign status_o = {3'b000, fl_q.err_eval, fl_q.err_exer, fl_q.aborted, running, fl_q.passed};

    AST_PASS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        fl_q.passed |-> (!fl_q.err_exer && !fl_q.err_eval)); // R4

    AST_RUN_FRESH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i != PH_IDLE) |-> (!fl_q.passed && !fl_q.aborted)); // R8

endmodule

// File: rtl/st_activity_map.sv
module st_activity_map
    import selftest_pkg::*;
(
    input  phase_e           phase_i,
    output logic [LVL_W-1:0] power_o,
    output logic [LVL_W-1:0] heat_o
);

    always_comb begin
        unique case (phase_i)
            PH_PREP: begin
                power_o = LVL_W'(PWR_PREP);
                heat_o  = LVL_W'(HEAT_PREP);
            end
            PH_EXER: begin
                power_o = LVL_W'(PWR_EXER);
                heat_o  = LVL_W'(HEAT_EXER);
            end
            PH_EVAL: begin
                power_o = LVL_W'(PWR_EVAL);
                heat_o  = LVL_W'(HEAT_EVAL);
            end
            default: begin
                power_o = '0;
                heat_o  = '0;
            end
        endcase
    end

endmodule

// File: rtl/selftest_sequencer.sv
module selftest_sequencer
    import selftest_pkg::*;
#(
    parameter int PREP_TICKS = 10,
    parameter int EXER_TICKS = 30,
    parameter int EVAL_TICKS = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr_i,
    input  logic [7:0] ctrl_data_i,
    output logic [7:0] status_o,
    output logic [6:0] power_o,
    output logic [6:0] heat_o
);

    cmd_t       cmd;
    logic       fresh;
    phase_e     phase;
    logic       phase_end;
    logic       start_ev;
    logic       abort_ev;
    logic [1:0] inj;

    st_cmd_reg u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (ctrl_wr_i),
        .data_i  (ctrl_data_i),
        .cmd_o   (cmd),
        .fresh_o (fresh)
    );

    st_phase_seq #(
        .PREP_TICKS (PREP_TICKS),
        .EXER_TICKS (EXER_TICKS),
        .EVAL_TICKS (EVAL_TICKS)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_i       (cmd),
        .fresh_i     (fresh),
        .phase_o     (phase),
        .phase_end_o (phase_end),
        .start_ev_o  (start_ev),
        .abort_ev_o  (abort_ev),
        .inj_o       (inj)
    );

    st_status_enc u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .phase_i     (phase),
        .phase_end_i (phase_end),
        .start_ev_i  (start_ev),
        .abort_ev_i  (abort_ev),
        .inj_i       (inj),
        .status_o    (status_o)
    );

    st_activity_map u_act (
        .phase_i (phase),
        .power_o (power_o),
        .heat_o  (heat_o)
    );

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !status_o[1] |-> (power_o == '0 && heat_o == '0)); // R10

endmodule

// File: tb/selftest_sequencer_tb_top.sv
module selftest_sequencer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_wr = 1'b0;
    logic [7:0] ctrl_data = 8'h00;
    logic [7:0] status;
    logic [6:0] power;
    logic [6:0] heat;

    selftest_sequencer dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_wr_i   (ctrl_wr),
        .ctrl_data_i (ctrl_data),
        .status_o    (status),
        .power_o     (power),
        .heat_o      (heat)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int         at;
        logic [7:0] st;
        int         ph;
        string      req;
    } exp_t;

    exp_t sb[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   reported = 0;

    function automatic int pwr_of(int ph);
        case (ph)
            1: return 40;
            2: return 90;
            3: return 50;
            default: return 0;
        endcase
    endfunction

    function automatic int heat_of(int ph);
        case (ph)
            1: return 20;
            2: return 70;
            3: return 40;
            default: return 0;
        endcase
    endfunction

    function automatic void push(int at, logic [7:0] st, int ph, string req);
        exp_t e;
        e.at = at; e.st = st; e.ph = ph; e.req = req;
        sb.push_back(e);
    endfunction

    function automatic void check(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s cycle %0d: actual 0x%0h expected 0x%0h", req, what, cyc, act, exp);
        end
    endfunction

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Monitor: compares scoreboard items when their cycle is reached
    initial begin
        forever begin
            @(posedge clk);
            #3;
            while (sb.size() > 0 && sb[0].at <= cyc) begin
                exp_t e;
                e = sb.pop_front();
                if (e.at < cyc) begin
                    check(e.req, "missed sample", cyc, e.at);
                end else begin
                    check(e.req, "status", int'(status), int'(e.st));
                    check(e.req, "power", int'(power), pwr_of(e.ph));
                    check(e.req, "heat", int'(heat), heat_of(e.ph));
                end
            end
        end
    end

    task automatic wr_ctrl(input logic [7:0] v);
        ctrl_data = v;
        ctrl_wr   = 1'b1;
        @(negedge clk);
        ctrl_wr   = 1'b0;
    endtask

    task automatic wait_to(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    // Driver: full run, pushes expectations for every phase boundary
    task automatic run_full(input logic [7:0] v, input logic [7:0] prev,
                            output logic [7:0] fin, input string req);
        int c, b, lp, le, lv;
        logic [7:0] ferr;
        @(negedge clk);
        c  = cyc;
        lp = v[4] ? 20 : 10;
        le = v[5] ? 60 : 30;
        lv = v[6] ? 40 : 20;
        b  = c + 2;
        ferr = {3'b000, v[3], v[2], 3'b000};
        fin  = ferr | {7'b0, (v[2] == 1'b0 && v[3] == 1'b0)};
        push(c + 1, prev, 0, req);
        push(b, 8'h02, 1, req);
        push(b + lp - 1, 8'h02, 1, req);
        push(b + lp, 8'h02, 2, req);
        push(b + lp + le - 1, 8'h02, 2, req);
        push(b + lp + le, 8'h02 | {4'b0, v[2], 3'b0}, 3, req);
        push(b + lp + le + lv - 1, 8'h02 | {4'b0, v[2], 3'b0}, 3, req);
        push(b + lp + le + lv, fin, 0, req);
        push(b + lp + le + lv + 2, fin, 0, req);
        wr_ctrl(v);
        wait_to(b + lp + le + lv + 3);
    endtask

    initial begin
        logic [7:0] st;
        int c, c2;
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11", "status reset", int'(status), 0);
        check("R11", "power reset", int'(power), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: data without strobe is ignored
        c = cyc;
        ctrl_data = 8'h01;
        push(c + 2, 8'h00, 0, "R1");
        push(c + 5, 8'h00, 0, "R1");
        wait_to(c + 6);
        ctrl_data = 8'h00;

        // R2 R4 R10: default run passes
        run_full(8'h01, 8'h00, st, "R2");
        // R3: all phases doubled; reserved bit7 set too
        run_full(8'hF1, st, st, "R3");
        // R5: exercise fault; R8 clears passed
        run_full(8'h05, st, st, "R5");
        // R5/R8: evaluation fault, previous exercise fault cleared
        run_full(8'h09, st, st, "R8");
        // R5: both faults
        run_full(8'h0D, st, st, "R5");

        // R9 and R6: start during run ignored, then abort+start in evaluation
        @(negedge clk);
        c = cyc;
        push(c + 2, 8'h02, 1, "R8");
        push(c + 12, 8'h02, 2, "R9");
        push(c + 19, 8'h02, 2, "R9");
        push(c + 41, 8'h02, 2, "R9");
        push(c + 42, 8'h0A, 3, "R9");
        wr_ctrl(8'h05);
        wait_to(c + 17);
        wr_ctrl(8'h31);
        wait_to(c + 47);
        c2 = cyc;
        push(c2 + 1, 8'h0A, 3, "R6");
        push(c2 + 2, 8'h0C, 0, "R6");
        push(c2 + 5, 8'h0C, 0, "R6");
        wr_ctrl(8'h03);
        wait_to(c2 + 6);

        // R7: abort while idle
        c = cyc;
        push(c + 2, 8'h0C, 0, "R7");
        push(c + 4, 8'h0C, 0, "R7");
        wr_ctrl(8'h02);
        wait_to(c + 5);

        // R8: start after abort clears aborted and faults
        run_full(8'h01, 8'h0C, st, "R8");

        // R6: abort during preparation
        @(negedge clk);
        c = cyc;
        push(c + 5, 8'h02, 1, "R6");
        wr_ctrl(8'h01);
        wait_to(c + 6);
        c2 = cyc;
        push(c2 + 2, 8'h04, 0, "R6");
        wr_ctrl(8'h02);
        wait_to(c2 + 4);

        // R11: reset in mid-run
        @(negedge clk);
        c = cyc;
        push(c + 15, 8'h02, 2, "R11");
        wr_ctrl(8'h01);
        wait_to(c + 16);
        rst_n = 1'b0;
        #1;
        check("R11", "status in reset", int'(status), 0);
        check("R11", "power in reset", int'(power), 0);
        check("R11", "heat in reset", int'(heat), 0);
        @(negedge clk);
        rst_n = 1'b1;
        c = cyc;
        push(c + 3, 8'h00, 0, "R11");
        wait_to(c + 5);

        if (sb.size() != 0) check("R2", "scoreboard leftover", sb.size(), 0);
        report();
    end

    initial begin
        #1_000_000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        report();
    end

endmodule